// File: doc/BRIEF.md
# Opcode-Keyed Fault Rule Manager

This block keeps a small table of fault-injection rules for a bit-level message engine that both receives and transmits. Each rule names a direction (receive or transmit), a fault type, an opcode key (one specific 8-bit opcode or a wildcard that matches any opcode), a trigger mode and an 8-bit argument. Software-side logic loads and removes rules through a single-cycle command port that takes either a rule write or a grouped clear.

When the message engine has latched the opcode byte of a message, it pulses `msg_start` with the direction and the opcode. The manager then compares that opcode with every stored rule and picks at most one rule for each fault type. A specific-opcode rule wins over a wildcard rule. The manager presents the chosen enables and arguments, then updates the rule state: one-shot rules are removed and alternating rules flip their phase.

The controller is one state machine with five states. `ST_IDLE` waits for work. `ST_EVAL` registers the match result. `ST_COMMIT` presents `res_valid` and updates rule state. `ST_WRITE` inserts, overwrites or removes a rule. `ST_CLEAR` drops every rule in the chosen group. The transitions are: idle to eval on `msg_start`; idle to write on an accepted write command; idle to clear on an accepted clear command; eval to commit; and commit, write and clear each back to idle. A message start takes priority over a command in the same cycle.

Top module: `fault_rule_mgr`

## Requirements
- R1: After reset the table is empty, `fault_en` is all zero, `res_valid` and `cmd_done` are low, and `cmd_ready` is high.
- R2: `res_valid` is high for exactly one cycle, two clock edges after the edge that samples `msg_start` in idle. `fault_en` and `fault_arg` change only in that result cycle and hold their values until the next result.
- R3: A rule applies only to messages whose direction matches (0 = receive, 1 = transmit). A rule with `cmd_any` = 0 matches only its own opcode, and a rule with `cmd_any` = 1 matches every opcode. For fault type f, `fault_en[f]` is set and `fault_arg[f*8 +: 8]` carries the chosen rule's argument; an arg slice whose enable is clear reads zero.
- R4: Mode 0 (once) fires on the first matching message and the rule is then removed from the table.
- R5: Mode 1 (always) fires on every matching message.
- R6: Mode 2 (toggle) fires on the 1st, 3rd, 5th ... message it is chosen for, and stays silent on the messages in between.
- R7: When a specific-opcode rule and a wildcard rule of the same direction and fault type both match, only the specific rule is used and only its state advances. The wildcard rule is not consumed.
- R8: Writing a key (direction, fault, wildcard flag, opcode) that is already stored replaces that rule's mode and argument, resets its toggle phase, and uses no extra slot.
- R9: Writing mode 3 (off) removes the stored rule with that key. If no such rule exists, the write has no effect and reports no error.
- R10: The table holds NUM_SLOTS (8) rules. A write of a new key in a mode other than off, made while all slots are full, raises `cmd_err` with `cmd_done` and leaves the table unchanged.
- R11: A clear command (`cmd_clear` = 1) drops the rules selected by `cmd_scope` (0 or 3 = both directions, 1 = receive only, 2 = transmit only). When `cmd_by_op` = 1, the clear is further limited to rules whose wildcard flag and opcode equal `cmd_any` and `cmd_opcode`.
- R12: `cmd_ready` is high only in idle with `msg_start` low. An accepted command (`cmd_valid` and `cmd_ready` high at a clock edge) is answered by `cmd_done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_clear | input | 1 | 1 = grouped clear, 0 = rule write |
| cmd_dir | input | 1 | Rule direction, 0 receive, 1 transmit |
| cmd_fault | input | 3 | Fault type index |
| cmd_any | input | 1 | Wildcard opcode key |
| cmd_opcode | input | 8 | Opcode key |
| cmd_mode | input | 2 | 0 once, 1 always, 2 toggle, 3 off |
| cmd_arg | input | 8 | Rule argument |
| cmd_scope | input | 2 | Clear group: 0/3 all, 1 receive, 2 transmit |
| cmd_by_op | input | 1 | Limit the clear to one opcode key |
| cmd_done | output | 1 | Command completed |
| cmd_err | output | 1 | Write rejected, table full |
| msg_start | input | 1 | Opcode of a new message is latched |
| msg_dir | input | 1 | Message direction |
| msg_opcode | input | 8 | Message opcode |
| res_valid | output | 1 | Evaluation result cycle |
| fault_en | output | 8 | One enable per fault type |
| fault_arg | output | 64 | Argument per fault type, 8 bits each |

## Verification
The assertions assume that `msg_start` and `cmd_valid` are synchronous to `clk` and that a command stays valid until it is accepted. The stimulus drives every input at the falling edge, holds `cmd_valid` across a collision with `msg_start` until `cmd_ready` returns, and issues each new operation only after the previous one has reached idle. Random writes draw from four fault types and three opcodes, with or without the wildcard. This key space is larger than the table, so the full-table rejection, overwrites, priority between specific and wildcard rules, and grouped clears all come up repeatedly against a bench model of the rule list.

// File: rtl/frm_pkg.sv
package frm_pkg;
    parameter int OP_W    = 8;
    parameter int ARG_W   = 8;
    parameter int FAULT_W = 3;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_ALWAYS = 2'd1,
        MODE_TOGGLE = 2'd2,
        MODE_OFF    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SCOPE_ALL  = 2'd0,
        SCOPE_RX   = 2'd1,
        SCOPE_TX   = 2'd2,
        SCOPE_BOTH = 2'd3
    } scope_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_COMMIT,
        ST_WRITE,
        ST_CLEAR
    } state_e;

    typedef struct packed {
        logic               valid;
        logic               dir;
        logic [FAULT_W-1:0] fault;
        logic               any;
        logic [OP_W-1:0]    opcode;
        mode_e              mode;
        logic               phase;
        logic [ARG_W-1:0]   arg;
    } rule_t;

    typedef struct packed {
        logic               dir;
        logic [FAULT_W-1:0] fault;
        logic               any;
        logic [OP_W-1:0]    opcode;
        mode_e              mode;
        logic [ARG_W-1:0]   arg;
        scope_e             scope;
        logic               by_op;
    } cmd_t;
endpackage

// File: rtl/frm_slot_match.sv
module frm_slot_match
    import frm_pkg::*;
(
    input  logic               s_valid,
    input  logic               s_dir,
    input  logic [FAULT_W-1:0] s_fault,
    input  logic               s_any,
    input  logic [OP_W-1:0]    s_opcode,
    input  logic               ev_dir,
    input  logic [OP_W-1:0]    ev_op,
    input  cmd_t               cmd,
    output logic               ev_spec,
    output logic               ev_wild,
    output logic               key_hit,
    output logic               clr_hit
);
    logic scope_ok;
    logic op_key_eq;

    always_comb begin
        op_key_eq = (s_any == cmd.any) && (cmd.any || (s_opcode == cmd.opcode));
        ev_spec   = s_valid && (s_dir == ev_dir) && !s_any && (s_opcode == ev_op);
        ev_wild   = s_valid && (s_dir == ev_dir) && s_any;
        key_hit   = s_valid && (s_dir == cmd.dir) && (s_fault == cmd.fault) && op_key_eq;
        unique case (cmd.scope)
            SCOPE_RX: scope_ok = !s_dir;
            SCOPE_TX: scope_ok = s_dir;
            default:  scope_ok = 1'b1;
        endcase
        clr_hit = s_valid && scope_ok && (!cmd.by_op || op_key_eq);
    end
endmodule

// File: rtl/frm_fault_pick.sv
module frm_fault_pick
    import frm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int FAULT_ID  = 0,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]              ev_spec,
    input  logic [NUM_SLOTS-1:0]              ev_wild,
    input  logic [NUM_SLOTS-1:0][FAULT_W-1:0] slot_fault,
    input  logic [NUM_SLOTS-1:0][1:0]         slot_mode,
    input  logic [NUM_SLOTS-1:0]              slot_phase,
    input  logic [NUM_SLOTS-1:0][ARG_W-1:0]   slot_arg,
    output logic                              en,
    output logic [ARG_W-1:0]                  arg,
    output logic [NUM_SLOTS-1:0]              chosen
);
    logic              spec_found, wild_found;
    logic [SLOT_W-1:0] spec_idx, wild_idx, idx;

    always_comb begin
        spec_found = 1'b0;
        wild_found = 1'b0;
        spec_idx   = '0;
        wild_idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_fault[i] == FAULT_W'(FAULT_ID)) begin
                if (ev_spec[i]) begin
                    spec_found = 1'b1;
                    spec_idx   = SLOT_W'(i);
                end
                if (ev_wild[i]) begin
                    wild_found = 1'b1;
                    wild_idx   = SLOT_W'(i);
                end
            end
        end
        idx    = spec_found ? spec_idx : wild_idx;
        chosen = (spec_found || wild_found) ? (NUM_SLOTS'(1) << idx) : '0;
        en     = (spec_found || wild_found) &&
                 !((slot_mode[idx] == MODE_TOGGLE) && slot_phase[idx]);
        arg    = en ? slot_arg[idx] : '0;
    end
endmodule

// File: rtl/fault_rule_mgr.sv
module fault_rule_mgr
    import frm_pkg::*;
#(
    parameter int NUM_SLOTS   = 8,
    localparam int NUM_FAULTS = 1 << FAULT_W,
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic                        cmd_clear,
    input  logic                        cmd_dir,
    input  logic [FAULT_W-1:0]          cmd_fault,
    input  logic                        cmd_any,
    input  logic [OP_W-1:0]             cmd_opcode,
    input  logic [1:0]                  cmd_mode,
    input  logic [ARG_W-1:0]            cmd_arg,
    input  logic [1:0]                  cmd_scope,
    input  logic                        cmd_by_op,
    output logic                        cmd_done,
    output logic                        cmd_err,
    input  logic                        msg_start,
    input  logic                        msg_dir,
    input  logic [OP_W-1:0]             msg_opcode,
    output logic                        res_valid,
    output logic [NUM_FAULTS-1:0]       fault_en,
    output logic [NUM_FAULTS*ARG_W-1:0] fault_arg
);
    state_e state, state_nx;
    rule_t  slots [NUM_SLOTS];
    cmd_t   cmd_q;
    logic            ev_dir_q;
    logic [OP_W-1:0] ev_op_q;

    logic [NUM_SLOTS-1:0]              slot_valid, slot_dir, slot_any, slot_phase;
    logic [NUM_SLOTS-1:0][FAULT_W-1:0] slot_fault;
    logic [NUM_SLOTS-1:0][OP_W-1:0]    slot_opcode;
    logic [NUM_SLOTS-1:0][1:0]         slot_mode;
    logic [NUM_SLOTS-1:0][ARG_W-1:0]   slot_arg;
    logic [NUM_SLOTS-1:0]              ev_spec, ev_wild, key_hit, clr_hit;

    logic [NUM_FAULTS-1:0]                pick_en;
    logic [NUM_FAULTS-1:0][ARG_W-1:0]     pick_arg;
    logic [NUM_FAULTS-1:0][NUM_SLOTS-1:0] pick_sel;
    logic [NUM_SLOTS-1:0]                 sel_d, fire_d, sel_q, fire_q;
    logic [NUM_FAULTS-1:0]                en_q;
    logic [NUM_FAULTS-1:0][ARG_W-1:0]     arg_q;

    logic              hit_any, free_any, write_err;
    logic [SLOT_W-1:0] hit_idx, free_idx;

    // Per-slot views and comparators
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_valid[s]  = slots[s].valid;
        assign slot_dir[s]    = slots[s].dir;
        assign slot_any[s]    = slots[s].any;
        assign slot_phase[s]  = slots[s].phase;
        assign slot_fault[s]  = slots[s].fault;
        assign slot_opcode[s] = slots[s].opcode;
        assign slot_mode[s]   = slots[s].mode;
        assign slot_arg[s]    = slots[s].arg;

        frm_slot_match u_match (
            .s_valid  (slot_valid[s]),
            .s_dir    (slot_dir[s]),
            .s_fault  (slot_fault[s]),
            .s_any    (slot_any[s]),
            .s_opcode (slot_opcode[s]),
            .ev_dir   (ev_dir_q),
            .ev_op    (ev_op_q),
            .cmd      (cmd_q),
            .ev_spec  (ev_spec[s]),
            .ev_wild  (ev_wild[s]),
            .key_hit  (key_hit[s]),
            .clr_hit  (clr_hit[s])
        );
    end

    // One priority picker per fault type
    for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_fault
        frm_fault_pick #(.NUM_SLOTS(NUM_SLOTS), .FAULT_ID(f)) u_pick (
            .ev_spec    (ev_spec),
            .ev_wild    (ev_wild),
            .slot_fault (slot_fault),
            .slot_mode  (slot_mode),
            .slot_phase (slot_phase),
            .slot_arg   (slot_arg),
            .en         (pick_en[f]),
            .arg        (pick_arg[f]),
            .chosen     (pick_sel[f])
        );
    end

    always_comb begin
        sel_d  = '0;
        fire_d = '0;
        for (int f = 0; f < NUM_FAULTS; f++) begin
            sel_d = sel_d | pick_sel[f];
            if (pick_en[f]) fire_d = fire_d | pick_sel[f];
        end
    end

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (key_hit[i]) begin
                hit_any = 1'b1;
                hit_idx = SLOT_W'(i);
            end
            if (!slot_valid[i]) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
        write_err = !hit_any && (cmd_q.mode != MODE_OFF) && !free_any;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (msg_start)      state_nx = ST_EVAL;
                else if (cmd_valid) state_nx = cmd_clear ? ST_CLEAR : ST_WRITE;
            end
            ST_EVAL:   state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_WRITE:  state_nx = ST_IDLE;
            ST_CLEAR:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        cmd_ready = 1'b0;
        cmd_done  = 1'b0;
        cmd_err   = 1'b0;
        res_valid = 1'b0;
        unique case (state)
            ST_IDLE:   cmd_ready = !msg_start;
            ST_EVAL:   ;
            ST_COMMIT: res_valid = 1'b1;
            ST_WRITE: begin
                cmd_done = 1'b1;
                cmd_err  = write_err;
            end
            ST_CLEAR:  cmd_done = 1'b1;
            default:   ;
        endcase
    end

    assign fault_en  = en_q;
    assign fault_arg = arg_q;

    // Rule table and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= '0;
            cmd_q    <= '0;
            ev_dir_q <= 1'b0;
            ev_op_q  <= '0;
            en_q     <= '0;
            arg_q    <= '0;
            sel_q    <= '0;
            fire_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (msg_start) begin
                        ev_dir_q <= msg_dir;
                        ev_op_q  <= msg_opcode;
                    end else if (cmd_valid) begin
                        cmd_q <= '{dir: cmd_dir, fault: cmd_fault, any: cmd_any,
                                   opcode: cmd_opcode, mode: mode_e'(cmd_mode),
                                   arg: cmd_arg, scope: scope_e'(cmd_scope),
                                   by_op: cmd_by_op};
                    end
                end
                ST_EVAL: begin
                    en_q   <= pick_en;
                    arg_q  <= pick_arg;
                    sel_q  <= sel_d;
                    fire_q <= fire_d;
                end
                ST_COMMIT: begin
                    for (int i = 0; i < NUM_SLOTS; i++) begin
                        if (sel_q[i]) begin
                            if (slots[i].mode == MODE_ONCE && fire_q[i])
                                slots[i].valid <= 1'b0;
                            if (slots[i].mode == MODE_TOGGLE)
                                slots[i].phase <= ~slots[i].phase;
                        end
                    end
                end
                ST_WRITE: begin
                    if (hit_any) begin
                        if (cmd_q.mode == MODE_OFF) begin
                            slots[hit_idx].valid <= 1'b0;
                        end else begin
                            slots[hit_idx].mode  <= cmd_q.mode;
                            slots[hit_idx].arg   <= cmd_q.arg;
                            slots[hit_idx].phase <= 1'b0;
                        end
                    end else if (cmd_q.mode != MODE_OFF && free_any) begin
                        slots[free_idx] <= '{valid: 1'b1, dir: cmd_q.dir,
                                             fault: cmd_q.fault, any: cmd_q.any,
                                             opcode: cmd_q.any ? '0 : cmd_q.opcode,
                                             mode: cmd_q.mode, phase: 1'b0,
                                             arg: cmd_q.arg};
                    end
                end
                ST_CLEAR: begin
                    for (int i = 0; i < NUM_SLOTS; i++)
                        if (clr_hit[i]) slots[i].valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/frm_checks.sv
module frm_checks
    import frm_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_FAULTS = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              msg_start,
    input logic                              cmd_valid,
    input logic                              cmd_ready,
    input logic                              cmd_done,
    input logic                              cmd_err,
    input logic                              res_valid,
    input logic [NUM_FAULTS-1:0]             fault_en,
    input logic [NUM_SLOTS-1:0]              slot_valid,
    input logic [NUM_SLOTS-1:0]              slot_dir,
    input logic [NUM_SLOTS-1:0]              slot_any,
    input logic [NUM_SLOTS-1:0]              slot_phase,
    input logic [NUM_SLOTS-1:0][FAULT_W-1:0] slot_fault,
    input logic [NUM_SLOTS-1:0][OP_W-1:0]    slot_opcode,
    input logic [NUM_SLOTS-1:0][1:0]         slot_mode
);
    logic dup_key, off_stored, phase_bad;

    always_comb begin
        dup_key    = 1'b0;
        off_stored = 1'b0;
        phase_bad  = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_valid[i] && slot_mode[i] == MODE_OFF) off_stored = 1'b1;
            if (slot_valid[i] && slot_phase[i] && slot_mode[i] != MODE_TOGGLE) phase_bad = 1'b1;
            for (int j = i + 1; j < NUM_SLOTS; j++) begin
                if (slot_valid[i] && slot_valid[j] && slot_dir[i] == slot_dir[j] &&
                    slot_fault[i] == slot_fault[j] && slot_any[i] == slot_any[j] &&
                    (slot_any[i] || slot_opcode[i] == slot_opcode[j]))
                    dup_key = 1'b1;
            end
        end
    end

    a_r2_result_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(msg_start, 2));

    a_r2_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(fault_en));

    a_r8_unique_keys: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_key);

    a_r9_off_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        !off_stored);

    a_r6_phase_toggle_only: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_bad);

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);

    a_r12_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!res_valid && !cmd_done));

    a_r12_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(cmd_valid && cmd_ready));
endmodule

bind fault_rule_mgr frm_checks #(.NUM_SLOTS(NUM_SLOTS), .NUM_FAULTS(NUM_FAULTS)) u_frm_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_start   (msg_start),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_done    (cmd_done),
    .cmd_err     (cmd_err),
    .res_valid   (res_valid),
    .fault_en    (fault_en),
    .slot_valid  (slot_valid),
    .slot_dir    (slot_dir),
    .slot_any    (slot_any),
    .slot_phase  (slot_phase),
    .slot_fault  (slot_fault),
    .slot_opcode (slot_opcode),
    .slot_mode   (slot_mode)
);

// File: tb/fault_rule_mgr_bench.sv
module fault_rule_mgr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NF = 8;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_clear = 1'b0, cmd_dir = 1'b0, cmd_any = 1'b0, cmd_by_op = 1'b0;
    logic [2:0] cmd_fault = '0;
    logic [7:0] cmd_opcode = '0, cmd_arg = '0;
    logic [1:0] cmd_mode = '0, cmd_scope = '0;
    logic msg_start = 1'b0, msg_dir = 1'b0;
    logic [7:0] msg_opcode = '0;
    logic cmd_ready, cmd_done, cmd_err, res_valid;
    logic [NF-1:0] fault_en;
    logic [NF*AW-1:0] fault_arg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench model of the rule list
    bit m_v[NS]; bit m_d[NS]; int m_f[NS]; bit m_a[NS]; int m_o[NS];
    int m_m[NS]; bit m_p[NS]; int m_g[NS];
    logic [NF-1:0] last_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_rule_mgr u_fault_rule_mgr (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_clear(cmd_clear),
        .cmd_dir(cmd_dir), .cmd_fault(cmd_fault), .cmd_any(cmd_any),
        .cmd_opcode(cmd_opcode), .cmd_mode(cmd_mode), .cmd_arg(cmd_arg),
        .cmd_scope(cmd_scope), .cmd_by_op(cmd_by_op),
        .cmd_done(cmd_done), .cmd_err(cmd_err),
        .msg_start(msg_start), .msg_dir(msg_dir), .msg_opcode(msg_opcode),
        .res_valid(res_valid), .fault_en(fault_en), .fault_arg(fault_arg)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit key_eq(int i, bit d, int f, bit a, int o);
        return m_v[i] && m_d[i] == d && m_f[i] == f && m_a[i] == a && (a || m_o[i] == o);
    endfunction

    function automatic bit model_write(bit d, int f, bit a, int o, int m, int g);
        int hit = -1;
        int fr = -1;
        for (int i = 0; i < NS; i++) begin
            if (key_eq(i, d, f, a, o)) hit = i;
            if (!m_v[i] && fr < 0) fr = i;
        end
        if (hit >= 0) begin
            if (m == 3) m_v[hit] = 0;
            else begin m_m[hit] = m; m_g[hit] = g; m_p[hit] = 0; end
            return 0;
        end
        if (m == 3) return 0;
        if (fr < 0) return 1;
        m_v[fr] = 1; m_d[fr] = d; m_f[fr] = f; m_a[fr] = a; m_o[fr] = o;
        m_m[fr] = m; m_p[fr] = 0; m_g[fr] = g;
        return 0;
    endfunction

    function automatic void model_clear(int sc, bit byop, bit a, int o);
        for (int i = 0; i < NS; i++) begin
            bit sok = (sc == 1) ? !m_d[i] : (sc == 2) ? m_d[i] : 1'b1;
            if (m_v[i] && sok && (!byop || (m_a[i] == a && (a || m_o[i] == o)))) m_v[i] = 0;
        end
    endfunction

    function automatic void model_eval(bit d, int o, output logic [NF-1:0] en,
                                       output logic [NF*AW-1:0] args);
        en = '0;
        args = '0;
        for (int f = 0; f < NF; f++) begin
            int sp = -1;
            int wi = -1;
            int c;
            for (int i = 0; i < NS; i++) begin
                if (m_v[i] && m_d[i] == d && m_f[i] == f) begin
                    if (!m_a[i] && m_o[i] == o) sp = i;
                    if (m_a[i]) wi = i;
                end
            end
            c = (sp >= 0) ? sp : wi;
            if (c >= 0) begin
                bit fire = !(m_m[c] == 2 && m_p[c]);
                if (fire) begin
                    en[f] = 1'b1;
                    args[f*AW +: AW] = 8'(m_g[c]);
                end
                if (m_m[c] == 0 && fire) m_v[c] = 0;
                if (m_m[c] == 2) m_p[c] = !m_p[c];
            end
        end
    endfunction

    task automatic do_write(input bit d, input int f, input bit a, input int o,
                            input int m, input int g, input string req);
        bit exp_err = model_write(d, f, a, o, m, g);
        @(negedge clk);
        chk({req, " ready"}, 64'(cmd_ready), 64'd1);
        cmd_valid = 1; cmd_clear = 0; cmd_dir = d; cmd_fault = 3'(f); cmd_any = a;
        cmd_opcode = 8'(o); cmd_mode = 2'(m); cmd_arg = 8'(g);
        @(negedge clk);
        cmd_valid = 0;
        chk({req, " done"}, 64'(cmd_done), 64'd1);
        chk({req, " err"}, 64'(cmd_err), 64'(exp_err));
        @(negedge clk);
    endtask

    task automatic do_clear(input int sc, input bit byop, input bit a, input int o,
                            input string req);
        model_clear(sc, byop, a, o);
        @(negedge clk);
        cmd_valid = 1; cmd_clear = 1; cmd_scope = 2'(sc); cmd_by_op = byop;
        cmd_any = a; cmd_opcode = 8'(o);
        @(negedge clk);
        cmd_valid = 0; cmd_clear = 0;
        chk({req, " clear done"}, 64'(cmd_done), 64'd1);
        @(negedge clk);
    endtask

    task automatic do_eval(input bit d, input int o, input string req);
        logic [NF-1:0] een;
        logic [NF*AW-1:0] earg;
        model_eval(d, o, een, earg);
        @(negedge clk);
        msg_dir = d; msg_opcode = 8'(o); msg_start = 1;
        @(negedge clk);
        msg_start = 0;
        chk("R2 no result in eval cycle", 64'(res_valid), 64'd0);
        @(negedge clk);
        chk("R2 result cycle", 64'(res_valid), 64'd1);
        chk({req, " fault_en"}, 64'(fault_en), 64'(een));
        chk({req, " fault_arg"}, fault_arg, earg);
        last_en = een;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd8191));
        for (int i = 0; i < NS; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 fault_en after reset", 64'(fault_en), 64'd0);
        chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
        chk("R1 cmd_done after reset", 64'(cmd_done), 64'd0);
        chk("R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);
        do_eval(0, 8'h10, "R1 empty table");

        // R4 once, R3 direction and opcode
        do_write(1, 2, 0, 8'h44, 0, 7, "R4 write once");
        do_eval(0, 8'h44, "R3 other direction");
        do_eval(1, 8'h45, "R3 other opcode");
        do_eval(1, 8'h44, "R4 once fires");
        chk("R4 once enable bit", 64'(fault_en), 64'h4);
        do_eval(1, 8'h44, "R4 once removed");
        chk("R4 once gone", 64'(fault_en), 64'h0);

        // R5 always, R3 wildcard
        do_write(0, 1, 1, 0, 1, 9, "R5 write always wildcard");
        do_eval(0, 8'h10, "R5 always first");
        do_eval(0, 8'h99, "R3 wildcard any opcode");
        chk("R5 always arg", 64'(fault_arg[15:8]), 64'd9);

        // R2 outputs hold through a command
        do_write(1, 5, 0, 8'h01, 1, 3, "R2 write between results");
        chk("R2 enables held", 64'(fault_en), 64'(last_en));

        // R6 toggle
        do_write(0, 0, 0, 8'h36, 2, 4, "R6 write toggle");
        do_eval(0, 8'h36, "R6 toggle first");
        chk("R6 toggle fires first", 64'(fault_en[0]), 64'd1);
        do_eval(0, 8'h36, "R6 toggle second");
        chk("R6 toggle silent second", 64'(fault_en[0]), 64'd0);
        do_eval(0, 8'h36, "R6 toggle third");

        // R7 specific over wildcard
        do_write(0, 1, 0, 8'h82, 0, 5, "R7 write specific once");
        do_eval(0, 8'h82, "R7 specific wins");
        chk("R7 specific arg", 64'(fault_arg[15:8]), 64'd5);
        do_eval(0, 8'h82, "R7 wildcard kept");
        chk("R7 wildcard arg", 64'(fault_arg[15:8]), 64'd9);

        // R8 overwrite
        do_write(0, 1, 1, 0, 1, 8'h33, "R8 overwrite wildcard");
        do_eval(0, 8'h12, "R8 new argument");

        // R9 off
        do_write(0, 1, 1, 0, 3, 0, "R9 off removes");
        do_eval(0, 8'h12, "R9 removed rule silent");
        do_write(1, 6, 0, 8'h70, 3, 0, "R9 off on absent key");

        // R10 full table
        do_clear(0, 0, 0, 0, "R11 clear all");
        for (int i = 0; i < NS; i++) do_write(i % 2, i % 4, 0, 8'h50 + i, 1, i + 1, "R10 fill");
        do_write(0, 7, 0, 8'h60, 1, 1, "R10 full rejects");
        do_write(0, 0, 0, 8'h50, 1, 8'hAA, "R8 overwrite when full");
        do_write(0, 7, 0, 8'h60, 3, 0, "R9 off when full");

        // R11 grouped clears
        do_clear(2, 0, 0, 0, "R11 clear transmit");
        do_eval(1, 8'h51, "R11 transmit gone");
        do_clear(1, 1, 0, 8'h52, "R11 clear receive one opcode");
        do_eval(0, 8'h52, "R11 opcode cleared");
        do_eval(0, 8'h54, "R11 other opcode kept");

        // R12 collision: message wins, command waits
        begin
            logic [NF-1:0] een;
            logic [NF*AW-1:0] earg;
            bit eerr;
            model_eval(0, 8'h50, een, earg);
            @(negedge clk);
            msg_start = 1; msg_dir = 0; msg_opcode = 8'h50;
            cmd_valid = 1; cmd_clear = 0; cmd_dir = 1; cmd_fault = 3; cmd_any = 1;
            cmd_mode = 1; cmd_arg = 8'h21;
            #1 chk("R12 ready low on collision", 64'(cmd_ready), 64'd0);
            @(negedge clk);
            msg_start = 0;
            chk("R12 ready low in eval", 64'(cmd_ready), 64'd0);
            @(negedge clk);
            chk("R12 message result first", 64'(fault_en), 64'(een));
            @(negedge clk);
            chk("R12 ready back in idle", 64'(cmd_ready), 64'd1);
            eerr = model_write(1, 3, 1, 0, 1, 8'h21);
            @(negedge clk);
            cmd_valid = 0;
            chk("R12 done after accept", 64'(cmd_done), 64'd1);
            chk("R12 err after accept", 64'(cmd_err), 64'(eerr));
            @(negedge clk);
        end

        // Random mix
        for (int n = 0; n < 500; n++) begin
            int k = $urandom_range(0, 99);
            bit d = 1'($urandom_range(0, 1));
            bit a = ($urandom_range(0, 3) == 0);
            int o = 8'h20 + $urandom_range(0, 2);
            if (k < 45)
                do_write(d, $urandom_range(0, 3), a, o, $urandom_range(0, 3),
                         $urandom_range(0, 255), "R8 R10 random write");
            else if (k < 53)
                do_clear($urandom_range(0, 3), 1'($urandom_range(0, 1)), a, o,
                         "R11 random clear");
            else
                do_eval(d, o, "R3 R7 random eval");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule